// File: doc/BRIEF.md
# Memory-Mapped Address Decoder with Console Ports

This block sits between the 16-bit address bus of a small processor and the things that bus can reach. It steers each access to one of several targets. Reads in the lower half of the map go to a program ROM. A 16K-word data RAM window occupies the next quarter. Three console ports sit just above the RAM window: a numeric output, a character output and a key input. Anything else reads as zero and ignores writes.

The selects for the ROM and RAM arrays are decoded in the same cycle as the request. The RAM receives a window-relative word address, which is the bus address minus the window base. Both arrays are assumed to return data one cycle after they are selected. The decoder therefore remembers the target of each read for one cycle and returns the matching data in the following cycle.

The console outputs are registered one-cycle strobes with their data alongside. A key read raises a one-cycle acknowledge in the cycle that carries the key code back, so the input port can move on to its next character. When a write and a read are requested together, the access counts as a write.

Top module: `mmio_addr_decoder`

## Requirements
- R1: A read with no write at an address below 0x8000 asserts rom_cs in the same cycle. In the next cycle bus_rdata equals rom_rdata.
- R2: A read or write at an address from 0x8000 to 0xBFFF asserts ram_cs in the same cycle. In that cycle ram_addr is the address minus 0x8000 (14 bits) and ram_we equals the write request. A read in this range returns ram_rdata on bus_rdata in the next cycle.
- R3: A write to 0xC000 raises num_valid in the next cycle, with num_data equal to the written word.
- R4: A write to 0xC001 raises chr_valid in the next cycle, with chr_data equal to bits 7:0 of the written word.
- R5: A read with no write from 0xC002 returns key_code, zero-extended to 16 bits, on bus_rdata in the next cycle. key_ack is high in that same cycle.
- R6: A read from any address at or above 0xC000 other than 0xC002 returns zero in the next cycle and asserts no select. This includes reads of the two output ports.
- R7: A write below 0x8000 or at an unmapped address at or above 0xC002 asserts neither rom_cs nor ram_cs and raises no strobe.
- R8: Each qualifying write or key read gives a pulse exactly one cycle long. Back-to-back writes to a port give back-to-back pulses, each carrying its own data. In a cycle that follows no read, bus_rdata is zero.
- R9: While rst_n is low at a clock edge, num_valid, chr_valid, key_ack and bus_rdata are low in the following cycle.
- R10: A cycle with both bus_we and bus_re high is a write only. It asserts no rom_cs, returns zero data and raises no key_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Word address of the access |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 16 | Read data, one cycle after the read |
| rom_cs | output | 1 | Program ROM select (reads only) |
| rom_rdata | input | 16 | ROM data, valid one cycle after rom_cs |
| ram_cs | output | 1 | Data RAM select |
| ram_we | output | 1 | Data RAM write enable |
| ram_addr | output | 14 | Window-relative RAM word address |
| ram_rdata | input | 16 | RAM data, valid one cycle after a RAM read |
| num_valid | output | 1 | Numeric output strobe |
| num_data | output | 16 | Numeric output word |
| chr_valid | output | 1 | Character output strobe |
| chr_data | output | 8 | Character output byte |
| key_code | input | 8 | Current key code from the input port |
| key_ack | output | 1 | Key consumed pulse |

## Verification
The selects and the RAM address are due in the request cycle itself. The bench samples them one time unit after it drives the request on the falling edge. The read data, key_ack and both console strobes are due one rising edge later. The bench samples them just after the next falling edge, and at that point it also drives the ROM, RAM and key input data that the response mux should pick. A third sample one cycle later confirms that every pulse has dropped and that bus_rdata has returned to zero. Back-to-back writes are checked on consecutive falling edges.

// File: rtl/mmio_pkg.sv
// Package: shared types for the memory-mapped address decoder.
// Assumes one access per cycle; the response source is remembered one cycle.
package mmio_pkg;

    // Where the data for a pending read comes from in the response cycle.
    typedef enum logic [2:0] {
        RSP_IDLE = 3'd0,
        RSP_ROM  = 3'd1,
        RSP_RAM  = 3'd2,
        RSP_KEY  = 3'd3,
        RSP_ZERO = 3'd4
    } rsp_src_e;

    // Result of decoding one bus address.
    typedef struct packed {
        logic in_rom;
        logic in_ram;
        logic is_num;
        logic is_chr;
        logic is_key;
    } addr_hit_t;

endpackage

// File: rtl/mmio_region_decode.sv
// Module: mmio_region_decode
// Purely combinational map of a bus address onto the ROM region, the RAM
// window, the three console ports, and the window-relative RAM offset.
// Assumes ROM_TOP <= RAM_BASE < RAM_TOP and that the ports fit below 2**ADDR_W.
module mmio_region_decode #(
    parameter int ADDR_W   = 16,
    parameter int ROM_TOP  = 32'h8000,
    parameter int RAM_BASE = 32'h8000,
    parameter int RAM_TOP  = 32'hC000,
    parameter int RAM_AW   = 14
) (
    input  logic [ADDR_W-1:0]          addr,
    output mmio_pkg::addr_hit_t        hit,
    output logic [RAM_AW-1:0]          ram_off
);
    localparam logic [ADDR_W-1:0] ROM_END_A  = ADDR_W'(ROM_TOP);
    localparam logic [ADDR_W-1:0] RAM_LO_A   = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] RAM_HI_A   = ADDR_W'(RAM_TOP);
    localparam logic [ADDR_W-1:0] PORT_NUM_A = ADDR_W'(RAM_TOP + 0);
    localparam logic [ADDR_W-1:0] PORT_CHR_A = ADDR_W'(RAM_TOP + 1);
    localparam logic [ADDR_W-1:0] PORT_KEY_A = ADDR_W'(RAM_TOP + 2);

    // Compare the address against every region and port boundary.
    always_comb begin
        hit.in_rom = (addr < ROM_END_A);
        hit.in_ram = (addr >= RAM_LO_A) && (addr < RAM_HI_A);
        hit.is_num = (addr == PORT_NUM_A);
        hit.is_chr = (addr == PORT_CHR_A);
        hit.is_key = (addr == PORT_KEY_A);
    end

    // Rebase the address onto the start of the RAM window.
    always_comb begin
        ram_off = RAM_AW'(addr - RAM_LO_A);
    end

endmodule

// File: rtl/mmio_console_out.sv
// Module: mmio_console_out
// Registers the numeric and character output strobes and their data.
// Each strobe is high for exactly the one cycle after its qualifying write.
// Data registers load only on a write, so they hold between strobes.
module mmio_console_out #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_num,
    input  logic              wr_chr,
    input  logic [DATA_W-1:0] wdata,
    output logic              num_valid,
    output logic [DATA_W-1:0] num_data,
    output logic              chr_valid,
    output logic [CHAR_W-1:0] chr_data
);
    // Strobe registers: one pulse per write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_valid <= 1'b0;
            chr_valid <= 1'b0;
        end else begin
            num_valid <= wr_num;
            chr_valid <= wr_chr;
        end
    end

    // Data registers: capture the written word or byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_data <= '0;
            chr_data <= '0;
        end else begin
            if (wr_num) num_data <= wdata;
            if (wr_chr) chr_data <= wdata[CHAR_W-1:0];
        end
    end

endmodule

// File: rtl/mmio_read_return.sv
// Module: mmio_read_return
// Remembers the source of a read for one cycle. In the following cycle it
// muxes the ROM, RAM or key data onto the read bus and pulses the key
// acknowledge. It assumes the arrays return data one cycle after select.
module mmio_read_return #(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  mmio_pkg::rsp_src_e    src_next,
    input  logic [DATA_W-1:0]     rom_rdata,
    input  logic [DATA_W-1:0]     ram_rdata,
    input  logic [CHAR_W-1:0]     key_code,
    output logic [DATA_W-1:0]     rdata,
    output logic                  key_ack
);
    mmio_pkg::rsp_src_e src_q;
    logic [DATA_W-1:0]  key_word;

    // Track the source of the read issued in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= mmio_pkg::RSP_IDLE;
        else        src_q <= src_next;
    end

    // Fit the key code to the data width: zero-pad or truncate.
    generate
        if (CHAR_W < DATA_W) begin : g_key_pad
            assign key_word = {{(DATA_W-CHAR_W){1'b0}}, key_code};
        end else begin : g_key_cut
            assign key_word = key_code[DATA_W-1:0];
        end
    endgenerate

    // Response mux: pick the data of the remembered source, else zero.
    always_comb begin
        case (src_q)
            mmio_pkg::RSP_ROM: rdata = rom_rdata;
            mmio_pkg::RSP_RAM: rdata = ram_rdata;
            mmio_pkg::RSP_KEY: rdata = key_word;
            default:           rdata = '0;
        endcase
    end

    // Key acknowledge is high exactly in the key response cycle.
    assign key_ack = (src_q == mmio_pkg::RSP_KEY);

endmodule

// File: rtl/mmio_addr_decoder.sv
// Module: mmio_addr_decoder (top)
// Decodes the processor address bus onto program ROM, a data RAM window and
// three console ports. Selects are combinational in the request cycle. Read
// data, key acknowledge and output strobes appear in the next cycle.
// Assumes one access per cycle; a cycle with both requests is a write.
module mmio_addr_decoder #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CHAR_W   = 8,
    parameter int RAM_BASE = 32'h8000,
    parameter int RAM_TOP  = 32'hC000,
    localparam int RAM_AW  = $clog2(RAM_TOP - RAM_BASE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rom_cs,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              num_valid,
    output logic [DATA_W-1:0] num_data,
    output logic              chr_valid,
    output logic [CHAR_W-1:0] chr_data,
    input  logic [CHAR_W-1:0] key_code,
    output logic              key_ack
);
    localparam int ROM_TOP = RAM_BASE;

    mmio_pkg::addr_hit_t hit;
    logic                rd_only;
    mmio_pkg::rsp_src_e  src_next;

    mmio_region_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_TOP  (ROM_TOP),
        .RAM_BASE (RAM_BASE),
        .RAM_TOP  (RAM_TOP),
        .RAM_AW   (RAM_AW)
    ) u_decode (
        .addr    (bus_addr),
        .hit     (hit),
        .ram_off (ram_addr)
    );

    // A read counts only when no write shares the cycle.
    assign rd_only = bus_re && !bus_we;

    // Array selects: ROM is read-only, RAM takes both directions.
    always_comb begin
        rom_cs = rd_only && hit.in_rom;
        ram_cs = (rd_only || bus_we) && hit.in_ram;
        ram_we = bus_we && hit.in_ram;
    end

    // Classify the read so the response stage knows its source.
    always_comb begin
        if (!rd_only)        src_next = mmio_pkg::RSP_IDLE;
        else if (hit.in_rom) src_next = mmio_pkg::RSP_ROM;
        else if (hit.in_ram) src_next = mmio_pkg::RSP_RAM;
        else if (hit.is_key) src_next = mmio_pkg::RSP_KEY;
        else                 src_next = mmio_pkg::RSP_ZERO;
    end

    mmio_console_out #(
        .DATA_W (DATA_W),
        .CHAR_W (CHAR_W)
    ) u_console (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_num    (bus_we && hit.is_num),
        .wr_chr    (bus_we && hit.is_chr),
        .wdata     (bus_wdata),
        .num_valid (num_valid),
        .num_data  (num_data),
        .chr_valid (chr_valid),
        .chr_data  (chr_data)
    );

    mmio_read_return #(
        .DATA_W (DATA_W),
        .CHAR_W (CHAR_W)
    ) u_return (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_next  (src_next),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .key_code  (key_code),
        .rdata     (bus_rdata),
        .key_ack   (key_ack)
    );

endmodule

// File: rtl/mmio_addr_decoder_chk.sv
// Module: mmio_addr_decoder_chk
// Port-level properties of the decoder, bound onto every instance of the top.
module mmio_addr_decoder_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CHAR_W   = 8,
    parameter int RAM_BASE = 32'h8000,
    parameter int RAM_TOP  = 32'hC000,
    parameter int RAM_AW   = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rom_cs,
    input logic              ram_cs,
    input logic              ram_we,
    input logic              num_valid,
    input logic [DATA_W-1:0] num_data,
    input logic              chr_valid,
    input logic [CHAR_W-1:0] chr_data,
    input logic [CHAR_W-1:0] key_code,
    input logic              key_ack
);
    localparam logic [ADDR_W-1:0] LO  = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] HI  = ADDR_W'(RAM_TOP);
    localparam logic [ADDR_W-1:0] NUM = ADDR_W'(RAM_TOP + 0);
    localparam logic [ADDR_W-1:0] CHR = ADDR_W'(RAM_TOP + 1);
    localparam logic [ADDR_W-1:0] KEY = ADDR_W'(RAM_TOP + 2);

    // R1: ROM select only on a plain read inside the ROM region.
    a_r1_rom_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (bus_re && !bus_we && bus_addr < LO));

    // R2: RAM select only inside the window; write enable implies select.
    a_r2_ram_sel_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || ram_we) |-> (ram_cs && bus_addr >= LO && bus_addr < HI));

    // R3: a numeric port write yields a strobe carrying the word.
    a_r3_num_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == NUM) |=> (num_valid && num_data == $past(bus_wdata)));

    // R4: a character port write yields a strobe carrying the low byte.
    a_r4_chr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CHR) |=> (chr_valid && chr_data == $past(bus_wdata[CHAR_W-1:0])));

    // R5: a key read returns the zero-extended key code with an acknowledge.
    a_r5_key_return: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_we && bus_addr == KEY) |=> (key_ack && bus_rdata == DATA_W'(key_code)));

    // R6: reads of the port area other than the key port return zero.
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && !bus_we && bus_addr >= HI && bus_addr != KEY) |=> (bus_rdata == '0 && !key_ack));

    // R7: writes outside the RAM window never select an array.
    a_r7_write_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr < LO || bus_addr >= HI)) |-> (!rom_cs && !ram_cs));

    // R8: a numeric strobe always traces back to a write one cycle earlier.
    a_r8_num_single: assert property (@(posedge clk) disable iff (!rst_n)
        num_valid |-> $past(bus_we && bus_addr == NUM));

    // R8: a key acknowledge always traces back to a key read one cycle earlier.
    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        key_ack |-> $past(bus_re && !bus_we && bus_addr == KEY));

    // R9: reset clears every registered output.
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!num_valid && !chr_valid && !key_ack && bus_rdata == '0));

    // R10: a combined write and read is never a ROM read.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_re) |-> !rom_cs);

endmodule

bind mmio_addr_decoder mmio_addr_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CHAR_W   (CHAR_W),
    .RAM_BASE (RAM_BASE),
    .RAM_TOP  (RAM_TOP),
    .RAM_AW   (RAM_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .num_valid (num_valid),
    .num_data  (num_data),
    .chr_valid (chr_valid),
    .chr_data  (chr_data),
    .key_code  (key_code),
    .key_ack   (key_ack)
);

// File: tb/mmio_addr_decoder_bench.sv
// Bench: seeded random accesses plus directed corner cases, checked against
// expectations computed from the requirements.
module mmio_addr_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr, bus_wdata, rom_rdata, ram_rdata;
    logic        bus_we, bus_re;
    logic [15:0] bus_rdata, num_data;
    logic        rom_cs, ram_cs, ram_we, num_valid, chr_valid, key_ack;
    logic [13:0] ram_addr;
    logic [7:0]  chr_data, key_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_addr_decoder u_mmio_addr_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .rom_cs(rom_cs), .rom_rdata(rom_rdata), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata), .num_valid(num_valid),
        .num_data(num_data), .chr_valid(chr_valid), .chr_data(chr_data),
        .key_code(key_code), .key_ack(key_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_rd(input bit we, input bit re);
        return re && !we;
    endfunction
    function automatic bit f_rom_cs(input bit we, input bit re, input logic [15:0] a);
        return f_rd(we, re) && a < 16'h8000;
    endfunction
    function automatic bit f_ram_cs(input bit we, input bit re, input logic [15:0] a);
        return (we || re) && a >= 16'h8000 && a < 16'hC000;
    endfunction
    function automatic logic [15:0] f_rdata(input bit we, input bit re, input logic [15:0] a,
                                            input logic [15:0] rom, input logic [15:0] ram,
                                            input logic [7:0] key);
        if (!f_rd(we, re))  return 16'h0;
        if (a < 16'h8000)   return rom;
        if (a < 16'hC000)   return ram;
        if (a == 16'hC002)  return {8'h00, key};
        return 16'h0;
    endfunction

    task automatic set_idle();
        bus_we = 1'b0; bus_re = 1'b0;
        bus_addr = 16'hFFFF; bus_wdata = 16'h0;
    endtask

    // One access: request cycle, response cycle, then a quiet cycle.
    task automatic access(input bit we, input bit re, input logic [15:0] a, input logic [15:0] wd);
        logic [15:0] rv_rom, rv_ram, exp_rd;
        logic [7:0]  rv_key;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd;
        #1;
        chk(rom_cs == f_rom_cs(we, re, a), "R1/R7/R10 rom_cs", rom_cs, f_rom_cs(we, re, a));
        chk(ram_cs == f_ram_cs(we, re, a), "R2/R7 ram_cs", ram_cs, f_ram_cs(we, re, a));
        chk(ram_we == (we && f_ram_cs(we, re, a)), "R2 ram_we", ram_we, we && f_ram_cs(we, re, a));
        if (f_ram_cs(we, re, a))
            chk(ram_addr == 14'(a - 16'h8000), "R2 ram_addr", ram_addr, 14'(a - 16'h8000));
        @(negedge clk);
        set_idle();
        rv_rom = 16'($urandom); rv_ram = 16'($urandom); rv_key = 8'($urandom);
        rom_rdata = rv_rom; ram_rdata = rv_ram; key_code = rv_key;
        #1;
        exp_rd = f_rdata(we, re, a, rv_rom, rv_ram, rv_key);
        chk(bus_rdata == exp_rd, "R1/R2/R5/R6/R10 bus_rdata", bus_rdata, exp_rd);
        chk(key_ack == (f_rd(we, re) && a == 16'hC002), "R5/R10 key_ack", key_ack, f_rd(we, re) && a == 16'hC002);
        chk(num_valid == (we && a == 16'hC000), "R3/R7 num_valid", num_valid, we && a == 16'hC000);
        if (we && a == 16'hC000) chk(num_data == wd, "R3 num_data", num_data, wd);
        chk(chr_valid == (we && a == 16'hC001), "R4/R7 chr_valid", chr_valid, we && a == 16'hC001);
        if (we && a == 16'hC001) chk(chr_data == wd[7:0], "R4 chr_data", chr_data, wd[7:0]);
        @(negedge clk);
        #1;
        chk(!num_valid && !chr_valid && !key_ack, "R8 pulses dropped",
            {num_valid, chr_valid, key_ack}, 0);
        chk(bus_rdata == 16'h0, "R8 rdata idle zero", bus_rdata, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        set_idle();
        rom_rdata = 16'h0; ram_rdata = 16'h0; key_code = 8'h0;
        // R9: requests during reset leave every registered output low.
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 16'hC000; bus_wdata = 16'h1234;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = 16'hC002; key_code = 8'h55;
        @(negedge clk);
        #1;
        chk(!num_valid && !chr_valid && !key_ack, "R9 reset strobes", {num_valid, chr_valid, key_ack}, 0);
        chk(bus_rdata == 16'h0, "R9 reset rdata", bus_rdata, 0);
        set_idle();
        rst_n = 1'b1;

        // Directed corners.
        access(1'b0, 1'b1, 16'h0000, 16'h0);   // R1 bottom of ROM
        access(1'b0, 1'b1, 16'h7FFF, 16'h0);   // R1 top of ROM
        access(1'b0, 1'b1, 16'h8000, 16'h0);   // R2 first RAM word
        access(1'b1, 1'b0, 16'hBFFF, 16'hA5A5); // R2 last RAM word write
        access(1'b0, 1'b1, 16'hC000, 16'h0);   // R6 read of output port
        access(1'b0, 1'b1, 16'hC001, 16'h0);   // R6
        access(1'b0, 1'b1, 16'hC002, 16'h0);   // R5 key read
        access(1'b0, 1'b1, 16'hFFFF, 16'h0);   // R6
        access(1'b1, 1'b0, 16'h1234, 16'hDEAD); // R7 write to ROM
        access(1'b1, 1'b0, 16'hC003, 16'hBEEF); // R7 unmapped write
        access(1'b1, 1'b0, 16'hC000, 16'h8001); // R3
        access(1'b1, 1'b0, 16'hC001, 16'h03C7); // R4 low byte only
        access(1'b1, 1'b1, 16'hC002, 16'h0);   // R10 combined on key port
        access(1'b1, 1'b1, 16'h0100, 16'h0);   // R10 combined on ROM

        // R8: back-to-back numeric writes give back-to-back pulses.
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 16'hC000; bus_wdata = 16'h1111;
        @(negedge clk);
        bus_wdata = 16'h2222;
        #1;
        chk(num_valid && num_data == 16'h1111, "R8 first pulse", num_data, 16'h1111);
        @(negedge clk);
        set_idle();
        #1;
        chk(num_valid && num_data == 16'h2222, "R8 second pulse", num_data, 16'h2222);
        @(negedge clk);
        #1;
        chk(!num_valid, "R8 pulse ends", num_valid, 0);

        // Seeded random accesses biased toward boundaries and ports.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            int cls = $urandom_range(0, 4);
            case (cls)
                0: a = 16'($urandom_range(0, 16'h7FFF));
                1: a = 16'($urandom_range(16'h8000, 16'hBFFF));
                2: a = 16'hC000 + 16'($urandom_range(0, 3));
                3: a = 16'($urandom_range(16'hC000, 16'hFFFF));
                default: a = 16'($urandom);
            endcase
            access(1'($urandom), 1'($urandom), a, 16'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule